// File: doc/BRIEF.md
# Rate-Select Periodic Divider with Update Timing

This block counts a 32.768 kHz clock-enable through a 15-bit divider chain held in a binary counter. A 4-bit rate code picks one bit of that counter as a tap. The tap drives two outputs:

- a square-wave pin, which is gated by an enable bit;
- a single-cycle periodic event on every rising edge of the tap.

A 3-bit divider-control code decides what the chain does: it counts, it is held in reset at its half-way point, or it is frozen.

The wrap of the chain marks the one-second update transfer. An update-in-progress flag goes high a few oscillator ticks before each wrap. It stays high for the whole update window. When the window ends, the flag drops and a one-cycle update strobe is produced. A set-inhibit input suppresses the window.

Interrupt flags, masking and the calendar counters are kept in neighbouring logic. They consume `periodic_tick`, `sec_strobe` and `uip`.

Top module: `rtc_rate_divider`

## Requirements
- R1: With rate code 0 the tap is off: `periodic_tick` never pulses and `sqw_out` stays low.
- R2: For rate codes 3 to 15 the tap is a square wave with a period of 2^(code-1) oscillator ticks. Code 1 gives a period of 128 ticks and code 2 gives 256 ticks. `periodic_tick` is a one-cycle pulse in the clock cycle after the oscillator tick that raises the tap.
- R3: `sqw_out` equals the tap level when the square-wave enable bit is 1, and is low otherwise. The enable bit is loaded from `sqwe_val` when `sqwe_wr` is high, and reset clears it.
- R4: The control code 010 is the only one that advances the chain. Codes 110 and 111 hold the chain at half count and keep `uip` low. Every other code freezes the chain and keeps `uip` low.
- R5: After the control code changes from a hold code (110 or 111) to 010, `uip` rises on the 16376th oscillator tick. The chain wraps, which is the update transfer, on the 16384th tick, which is half a second later.
- R6: `uip` rises on the oscillator tick that brings the chain to 8 ticks before its wrap.
- R7: `uip` stays high for 73 oscillator ticks, which is about 2.2 ms. When it falls, `sec_strobe` pulses for exactly one cycle.
- R8: While `set_inh` is 1, `uip` is cleared on the next clock, `uip` does not rise, and no `sec_strobe` is produced.
- R9: After reset, `periodic_tick`, `sqw_out`, `uip` and `sec_strobe` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One-cycle enable at the 32.768 kHz oscillator rate |
| rate_sel | input | 4 | Tap select code |
| dv_ctl | input | 3 | Divider control code |
| set_inh | input | 1 | Update inhibit |
| sqwe_wr | input | 1 | Write strobe for the square-wave enable bit |
| sqwe_val | input | 1 | Value loaded into the square-wave enable bit |
| periodic_tick | output | 1 | One-cycle pulse on each rising edge of the tap |
| sqw_out | output | 1 | Gated square-wave output |
| uip | output | 1 | Update-in-progress window |
| sec_strobe | output | 1 | One-cycle pulse at the end of each update window |

## Verification
The assertions assume two things about the inputs. First, the rate code and the enable bit are the values the neighbouring register logic holds, so a tick is compared against the tap only when the rate code did not change across that edge. Second, `set_inh` and `dv_ctl` are ordinary synchronous levels. The bench drives every input on the falling edge so that each value is seen at a single rising edge. It changes the rate only between measurements. The oscillator enable follows three patterns: every cycle, every third cycle, and a pseudo-random sequence. The last pattern shows that all timing counts oscillator ticks and not clock cycles.

// File: rtl/rtc_rate_divider.sv
module rtc_rate_divider #(
  parameter int STAGES    = 15,
  parameter int PRE_TICKS = 8,
  parameter int WIN_TICKS = 73
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_tick,
  input  logic [3:0] rate_sel,
  input  logic [2:0] dv_ctl,
  input  logic       set_inh,
  input  logic       sqwe_wr,
  input  logic       sqwe_val,
  output logic       periodic_tick,
  output logic       sqw_out,
  output logic       uip,
  output logic       sec_strobe
);
  localparam int IW = $clog2(STAGES);
  localparam int WW = $clog2(WIN_TICKS + 1);
  localparam logic [STAGES-1:0] HALF   = STAGES'(1 << (STAGES - 1));
  localparam logic [STAGES-1:0] UIP_AT = STAGES'((1 << STAGES) - PRE_TICKS);
  localparam logic [WW-1:0]     WIN_LAST = WW'(WIN_TICKS - 1);

  logic [STAGES-1:0] cnt, cnt_nxt;
  logic [IW-1:0]     tap_idx;
  logic [WW-1:0]     win;
  logic              sqwe, rate_on, run, hold, adv, tap_rise;

  always_comb begin
    case (rate_sel)
      4'd0:    tap_idx = '0;
      4'd1:    tap_idx = IW'(6);
      4'd2:    tap_idx = IW'(7);
      default: tap_idx = IW'(rate_sel - 4'd2);
    endcase
  end

  assign rate_on  = |rate_sel;
  assign run      = (dv_ctl == 3'b010);
  assign hold     = (dv_ctl[2:1] == 2'b11);
  assign adv      = run & osc_tick;
  assign cnt_nxt  = cnt + 1'b1;
  assign tap_rise = rate_on & cnt_nxt[tap_idx] & ~cnt[tap_idx];
  assign sqw_out  = sqwe & rate_on & cnt[tap_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt           <= HALF;
      periodic_tick <= 1'b0;
      sqwe          <= 1'b0;
    end else begin
      if (sqwe_wr) sqwe <= sqwe_val;
      periodic_tick <= adv & tap_rise;
      if (hold)     cnt <= HALF;
      else if (adv) cnt <= cnt_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      uip        <= 1'b0;
      win        <= '0;
      sec_strobe <= 1'b0;
    end else begin
      sec_strobe <= 1'b0;
      if (set_inh || !run) begin
        uip <= 1'b0;
        win <= '0;
      end else if (osc_tick) begin
        if (uip) begin
          if (win == WIN_LAST) begin
            uip        <= 1'b0;
            sec_strobe <= 1'b1;
          end else begin
            win <= win + 1'b1;
          end
        end else if (cnt_nxt == UIP_AT) begin
          uip <= 1'b1;
          win <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/rtc_rate_divider_chk.sv
module rtc_rate_divider_chk #(
  parameter int STAGES = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        rate_sel,
  input logic [2:0]        dv_ctl,
  input logic              set_inh,
  input logic              sqwe,
  input logic [STAGES-1:0] cnt,
  input logic              periodic_tick,
  input logic              sqw_out,
  input logic              uip,
  input logic              sec_strobe
);
  localparam logic [STAGES-1:0] HALF = STAGES'(1 << (STAGES - 1));

  p_rate_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    periodic_tick |-> ($past(rate_sel) != 4'd0));

  p_tick_on_high_tap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (periodic_tick && sqwe && rate_sel == $past(rate_sel)) |-> sqw_out);

  p_sqw_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sqwe |-> !sqw_out);

  p_hold_chain_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dv_ctl[2:1]) == 2'b11) |-> (cnt == HALF && !uip));

  p_strobe_at_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sec_strobe |-> $fell(uip));

  p_set_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(set_inh) |-> (!uip && !sec_strobe));
endmodule

bind rtc_rate_divider rtc_rate_divider_chk #(.STAGES(STAGES)) chk_i (
  .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .dv_ctl(dv_ctl),
  .set_inh(set_inh), .sqwe(sqwe), .cnt(cnt), .periodic_tick(periodic_tick),
  .sqw_out(sqw_out), .uip(uip), .sec_strobe(sec_strobe)
);

// File: tb/rtc_rate_divider_tb_top.sv
`timescale 1ns/1ps
module rtc_rate_divider_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_tick = 1'b1;
  logic [3:0] rate_sel = 4'd3;
  logic [2:0] dv_ctl = 3'b110;
  logic set_inh = 1'b0, sqwe_wr = 1'b0, sqwe_val = 1'b0;
  logic periodic_tick, sqw_out, uip, sec_strobe;

  int checks = 0, errors = 0;
  int osc_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  int osc_div = 0;

  always #2 clk = ~clk;

  rtc_rate_divider dut_i (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .rate_sel(rate_sel),
    .dv_ctl(dv_ctl), .set_inh(set_inh), .sqwe_wr(sqwe_wr), .sqwe_val(sqwe_val),
    .periodic_tick(periodic_tick), .sqw_out(sqw_out), .uip(uip), .sec_strobe(sec_strobe)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    osc_div <= (osc_div == 2) ? 0 : osc_div + 1;
    case (osc_mode)
      0: osc_tick <= 1'b1;
      1: osc_tick <= lfsr[0];
      default: osc_tick <= (osc_div == 0);
    endcase
  end

  // Behavioural reference
  int m_cnt, m_win;
  bit m_uip, m_tick, m_str, m_sqwe;

  function automatic int period_of(input int r);
    if (r == 1) return 128;
    if (r == 2) return 256;
    return 32768 / (32768 >> (r - 1));
  endfunction

  function automatic bit level_of(input int c, input int r);
    int p;
    if (r == 0) return 1'b0;
    p = period_of(r);
    return (c % p) >= (p / 2);
  endfunction

  always @(posedge clk) begin
    int nc;
    bit run;
    if (!rst_n) begin
      m_cnt = 16384; m_win = 0; m_uip = 0; m_tick = 0; m_str = 0; m_sqwe = 0;
    end else begin
      m_tick = 0; m_str = 0;
      if (sqwe_wr) m_sqwe = sqwe_val;
      run = (dv_ctl == 3'b010);
      nc = (m_cnt + 1) % 32768;
      if (run && osc_tick && level_of(nc, rate_sel) && !level_of(m_cnt, rate_sel)) m_tick = 1;
      if (set_inh || !run) begin
        m_uip = 0; m_win = 0;
      end else if (osc_tick) begin
        if (m_uip) begin
          if (m_win == 72) begin m_uip = 0; m_str = 1; end
          else m_win++;
        end else if (nc == 32760) begin
          m_uip = 1; m_win = 0;
        end
      end
      if (dv_ctl >= 3'b110) m_cnt = 16384;
      else if (run && osc_tick) m_cnt = nc;
    end
    #1;
    chk("R2", "periodic_tick", periodic_tick, m_tick);
    chk("R3", "sqw_out", sqw_out, m_sqwe & level_of(m_cnt, rate_sel));
    chk("R6", "uip", uip, m_uip);
    chk("R7", "sec_strobe", sec_strobe, m_str);
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_sqwe(input logic v);
    @(negedge clk); sqwe_wr = 1'b1; sqwe_val = v;
    @(negedge clk); sqwe_wr = 1'b0;
  endtask

  task automatic count_ticks(input int n, output int ticks, output int sqw_hi);
    ticks = 0; sqw_hi = 0;
    repeat (n) begin
      @(posedge clk); #1;
      if (periodic_tick) ticks++;
      if (sqw_out) sqw_hi++;
    end
  endtask

  task automatic measure_period(input logic [3:0] r, input int exp);
    int n;
    @(negedge clk); rate_sel = r;
    for (int k = 0; k < 2; k++) begin
      n = 0;
      do begin @(posedge clk); #1; n++; end while (!periodic_tick && n < 2000);
    end
    chk("R2", $sformatf("tick period rate %0d", r), n, exp);
  endtask

  initial begin
    int n, t, s;
    logic frozen;
    cyc(3);
    chk("R9", "reset tick", periodic_tick, 0);
    chk("R9", "reset sqw", sqw_out, 0);
    chk("R9", "reset uip", uip, 0);
    chk("R9", "reset strobe", sec_strobe, 0);
    @(negedge clk); rst_n = 1'b1;
    write_sqwe(1'b1);

    // R4: hold code 110 keeps the chain still
    count_ticks(200, t, s);
    chk("R4", "ticks while held", t, 0);
    chk("R4", "sqw high while held", s, 0);

    // R5 / R7: release to 010
    @(negedge clk); dv_ctl = 3'b010;
    n = 0;
    do begin @(posedge clk); #1; n++; end while (!uip && n < 20000);
    chk("R5", "ticks to uip rise", n, 16376);
    do begin @(posedge clk); #1; n++; end while (!sec_strobe && n < 20000);
    chk("R7", "ticks to update strobe", n, 16376 + 73);
    @(posedge clk); #1;
    chk("R7", "strobe width", sec_strobe, 0);

    measure_period(4'd3, 4);
    measure_period(4'd6, 32);
    measure_period(4'd1, 128);
    measure_period(4'd2, 256);

    // R1
    @(negedge clk); rate_sel = 4'd0;
    count_ticks(600, t, s);
    chk("R1", "ticks with rate 0", t, 0);
    chk("R1", "sqw high with rate 0", s, 0);

    // R3
    @(negedge clk); rate_sel = 4'd3;
    write_sqwe(1'b0);
    count_ticks(100, t, s);
    chk("R3", "sqw high with enable off", s, 0);
    chk("R2", "ticks with enable off", t, 25);
    write_sqwe(1'b1);

    // R4: code 000 freezes
    @(negedge clk); dv_ctl = 3'b000;
    @(posedge clk); #1; frozen = sqw_out;
    n = 0;
    repeat (100) begin @(posedge clk); #1; if (sqw_out != frozen || periodic_tick || uip) n++; end
    chk("R4", "changes while frozen", n, 0);
    @(negedge clk); dv_ctl = 3'b010;

    // R8
    n = 0;
    do begin @(posedge clk); #1; n++; end while (!uip && n < 70000);
    chk("R6", "uip seen before set test", uip, 1);
    @(negedge clk); set_inh = 1'b1;
    @(posedge clk); #1;
    chk("R8", "uip after set", uip, 0);
    n = 0;
    repeat (300) begin @(posedge clk); #1; if (sec_strobe || uip) n++; end
    chk("R8", "activity while set", n, 0);
    @(negedge clk); set_inh = 1'b0;

    // Irregular oscillator ticks
    rate_sel = 4'd5;
    osc_mode = 1;
    cyc(20000);
    osc_mode = 2;
    cyc(20000);
    osc_mode = 0;

    // Reset clears the square-wave enable
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    count_ticks(64, t, s);
    chk("R3", "sqw after reset", s, 0);
    chk("R9", "uip after reset", uip, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog run did not end");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule